// File: doc/BRIEF.md
# Serial Gain Command Loader for a Dual Programmable-Gain Amplifier

This block programs both channels of a dual programmable-gain amplifier over a three-wire serial link. A one-cycle start strobe captures two 4-bit gain codes. The block then pulls chip select low and clocks out an 8-bit command, most significant bit first. It raises chip select again so that the amplifier applies the new gains. The serial clock is made from the system clock by a phase counter. Each phase lasts a whole number of system cycles, chosen so that the amplifier's minimum high, low, setup and chip-select timings are met at the system clock rate in use.

The command word has channel B's code in the upper nibble and channel A's code in the lower nibble. On the same transfer, the amplifier returns its previous setting on its data output. The block samples that line at every rising serial clock edge and presents the captured byte when it signals completion. The amplifier shutdown line is held high while the block is in reset and held low at all other times. As examples of codes, 0001 selects a gain of -1 (the widest input range) and 0000 selects zero gain. The block passes the codes through without interpreting them.

Top module: `pga_gain_loader`

## Requirements
- R1: The transmitted word is {gain_b, gain_a}. Bit 7 (B3) goes first and bit 0 (A0) goes last. Each frame has exactly 8 rising serial clock edges while chip select is low, and `amp_mosi` holds the current bit at each rising edge.
- R2: The gain codes are captured only on the cycle that accepts `start`. Changing `gain_a` or `gain_b` during a frame does not change the word the amplifier receives.
- R3: `amp_cs_n` falls on the clock edge that accepts `start` while idle, and `amp_mosi` carries B3 from that edge. The first rising edge of `amp_sck` follows exactly PHASE_CYC cycles later.
- R4: Each high phase and each low phase of `amp_sck` lasts exactly PHASE_CYC cycles. `amp_mosi` changes only when `amp_sck` falls or when `amp_cs_n` falls, so it is stable for PHASE_CYC cycles before every rising edge.
- R5: `amp_cs_n` rises exactly TRAIL_CYC cycles after the last falling edge of `amp_sck`. `amp_sck` is low whenever `amp_cs_n` is high.
- R6: `done` is a pulse of exactly one cycle. It is raised one cycle after `amp_cs_n` rises.
- R7: `amp_miso` is sampled at each rising edge of `amp_sck`, with the first sample becoming bit 7. The byte appears on `echo` in the cycle `done` is high and holds until the next `done`.
- R8: After `amp_cs_n` rises, it stays high for at least GAP_CYC cycles. A `start` that arrives during a frame or during that gap is ignored and produces no extra frame.
- R9: While `rst_n` is low, `amp_cs_n`=1, `amp_sck`=0, `amp_mosi`=0, `done`=0, `echo`=0 and `amp_shdn`=1. From the first clock edge after reset is released, `amp_shdn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that starts a load when the block is idle |
| gain_a | input | FIELD_W | Gain code for channel A (low nibble of the command) |
| gain_b | input | FIELD_W | Gain code for channel B (high nibble, sent first) |
| amp_miso | input | 1 | Echoed previous setting from the amplifier |
| amp_cs_n | output | 1 | Active-low chip select; the gain applies when it rises |
| amp_sck | output | 1 | Serial clock; the amplifier samples on its rising edge |
| amp_mosi | output | 1 | Serial command data, MSB first |
| amp_shdn | output | 1 | Active-high amplifier shutdown |
| done | output | 1 | One-cycle completion pulse |
| echo | output | 2*FIELD_W | Previous amplifier setting captured during the frame |

## Verification
The embedded properties check, on every cycle, the invariants that involve only local timing:
- the serial clock stays idle while chip select is high;
- the data line moves only on a falling clock edge or when chip select falls;
- `done` follows the rise of chip select by one cycle and lasts one cycle;
- a frame begins only from the idle state;
- the phase counter stays within its bound.

Only the bench scenarios can show the end-to-end behaviour. This covers the bit order seen by a modelled amplifier and the exact phase, lead and trail lengths counted in cycles. It also covers the echo matching the previous frame's word, the immunity to gain changes in mid-frame, and the dropping of start strobes sent during a frame or in the gap after it.

// File: rtl/pga_pkg.sv
package pga_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOW   = 3'd1,
        ST_HIGH  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_GAP   = 3'd4
    } pga_state_e;

    // Bits needed to hold values 0..v (at least one bit).
    function automatic int bits_for(input int v);
        int w;
        w = 1;
        while ((1 << w) <= v) w++;
        return w;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pga_phase_timer.sv
module pga_phase_timer #(
    parameter int W    = 3,
    parameter int MAXV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load)
            count_d = load_val;
        else if (count_q != '0)
            count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expired = (count_q == '0);

    // R4: the phase counter never exceeds the longest loaded phase
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= W'(MAXV));

endmodule

// File: rtl/pga_shift_pair.sv
module pga_shift_pair #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         sample,
    input  logic         sdi,
    output logic         sdo,
    output logic [W-1:0] rx_word
);

    logic [W-1:0] tx_d, tx_q;
    logic [W-1:0] rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load) begin
            tx_d = load_word;
            rx_d = '0;
        end else begin
            if (shift)  tx_d = {tx_q[W-2:0], 1'b0};
            if (sample) rx_d = {rx_q[W-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign sdo     = tx_q[W-1];
    assign rx_word = rx_q;

endmodule

// File: rtl/pga_gain_loader.sv
module pga_gain_loader
    import pga_pkg::*;
#(
    parameter int PHASE_CYC = 5,
    parameter int TRAIL_CYC = 3,
    parameter int GAP_CYC   = 3,
    parameter int FIELD_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [FIELD_W-1:0]     gain_a,
    input  logic [FIELD_W-1:0]     gain_b,
    input  logic                   amp_miso,
    output logic                   amp_cs_n,
    output logic                   amp_sck,
    output logic                   amp_mosi,
    output logic                   amp_shdn,
    output logic                   done,
    output logic [2*FIELD_W-1:0]   echo
);

    localparam int CMD_W = 2 * FIELD_W;
    localparam int TMAX  = max3(PHASE_CYC - 1, TRAIL_CYC - 1, GAP_CYC - 1);
    localparam int TW    = bits_for(TMAX);
    localparam int BW    = bits_for(CMD_W - 1);

    typedef struct packed {
        pga_state_e       state;
        logic             cs_n;
        logic             sck;
        logic [BW-1:0]    bits;
        logic             fresh;
        logic             done;
        logic [CMD_W-1:0] echo;
        logic             shdn;
    } regs_t;

    regs_t q_r, d_r;

    logic             t_load;
    logic [TW-1:0]    t_val;
    logic             t_expired;
    logic             sh_load, sh_shift, sh_sample;
    logic             sh_sdo;
    logic [CMD_W-1:0] sh_rx;

    pga_phase_timer #(.W(TW), .MAXV(TMAX)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    pga_shift_pair #(.W(CMD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word ({gain_b, gain_a}),
        .shift     (sh_shift),
        .sample    (sh_sample),
        .sdi       (amp_miso),
        .sdo       (sh_sdo),
        .rx_word   (sh_rx)
    );

    always_comb begin
        d_r       = q_r;
        d_r.shdn  = 1'b0;
        d_r.done  = q_r.fresh;
        d_r.fresh = 1'b0;
        if (q_r.fresh) d_r.echo = sh_rx;

        t_load    = 1'b0;
        t_val     = '0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        sh_sample = 1'b0;

        unique case (q_r.state)
            ST_IDLE: begin
                if (start) begin
                    d_r.state = ST_LOW;
                    d_r.cs_n  = 1'b0;
                    d_r.bits  = '0;
                    sh_load   = 1'b1;
                    t_load    = 1'b1;
                    t_val     = TW'(PHASE_CYC - 1);
                end
            end
            ST_LOW: begin
                if (t_expired) begin
                    d_r.state = ST_HIGH;
                    d_r.sck   = 1'b1;
                    sh_sample = 1'b1;
                    t_load    = 1'b1;
                    t_val     = TW'(PHASE_CYC - 1);
                end
            end
            ST_HIGH: begin
                if (t_expired) begin
                    d_r.sck  = 1'b0;
                    sh_shift = 1'b1;
                    t_load   = 1'b1;
                    if (q_r.bits == BW'(CMD_W - 1)) begin
                        d_r.state = ST_TRAIL;
                        t_val     = TW'(TRAIL_CYC - 1);
                    end else begin
                        d_r.state = ST_LOW;
                        d_r.bits  = q_r.bits + 1'b1;
                        t_val     = TW'(PHASE_CYC - 1);
                    end
                end
            end
            ST_TRAIL: begin
                if (t_expired) begin
                    d_r.state = ST_GAP;
                    d_r.cs_n  = 1'b1;
                    d_r.fresh = 1'b1;
                    t_load    = 1'b1;
                    t_val     = TW'(GAP_CYC - 1);
                end
            end
            ST_GAP: begin
                if (t_expired) d_r.state = ST_IDLE;
            end
            default: d_r.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r.state <= ST_IDLE;
            q_r.cs_n  <= 1'b1;
            q_r.sck   <= 1'b0;
            q_r.bits  <= '0;
            q_r.fresh <= 1'b0;
            q_r.done  <= 1'b0;
            q_r.echo  <= '0;
            q_r.shdn  <= 1'b1;
        end else begin
            q_r <= d_r;
        end
    end

    assign amp_cs_n = q_r.cs_n;
    assign amp_sck  = q_r.sck;
    assign amp_mosi = sh_sdo;
    assign amp_shdn = q_r.shdn;
    assign done     = q_r.done;
    assign echo     = q_r.echo;

    // R5: serial clock idles low outside a frame
    p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_r.cs_n |-> !q_r.sck);

    // R4: data moves only on a falling clock or the opening of a frame
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(q_r.sck) && !$fell(q_r.cs_n)) |-> $stable(sh_sdo));

    // R6: completion follows the chip-select rise by one cycle
    p_done_after_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_r.cs_n) |=> q_r.done);

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_r.done |=> !q_r.done);

    // R8: a frame can open only from the idle state
    p_open_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_r.cs_n) |-> $past(q_r.state == ST_IDLE));

endmodule

// File: tb/pga_gain_loader_tb.sv
module pga_gain_loader_tb;

    localparam int P = 5;
    localparam int T = 3;
    localparam int G = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [3:0] gain_a, gain_b;
    logic       amp_miso;
    logic       amp_cs_n, amp_sck, amp_mosi, amp_shdn, done;
    logic [7:0] echo;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pga_gain_loader #(.PHASE_CYC(P), .TRAIL_CYC(T), .GAP_CYC(G), .FIELD_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gain_a(gain_a), .gain_b(gain_b),
        .amp_miso(amp_miso), .amp_cs_n(amp_cs_n), .amp_sck(amp_sck),
        .amp_mosi(amp_mosi), .amp_shdn(amp_shdn), .done(done), .echo(echo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Amplifier model: samples on rising sck, echoes its old setting after falling sck
    logic [7:0] amp_set = 8'h00, amp_rx = 8'h00, amp_tx = 8'h00, amp_last = 8'h00;
    initial amp_miso = 1'b0;
    always @(negedge amp_cs_n) begin
        amp_tx   = amp_set;
        amp_miso = amp_set[7];
    end
    always @(negedge amp_sck) if (!amp_cs_n) begin
        amp_tx   = amp_tx << 1;
        amp_miso = amp_tx[7];
    end
    always @(posedge amp_sck) if (!amp_cs_n) amp_rx = {amp_rx[6:0], amp_mosi};
    always @(posedge amp_cs_n) begin
        amp_set  = amp_rx;
        amp_last = amp_rx;
    end

    // Scoreboard
    logic [7:0] exp_cmd_q[$];
    logic [7:0] exp_echo_q[$];
    logic [7:0] prev_cmd = 8'h00;
    int frames_sent = 0;
    int frames_done = 0;
    int cs_falls    = 0;

    // Monitor, sampling away from the active edge
    logic       cs_p = 1'b1, sck_p = 1'b0;
    int         run = 0, since_rise = 1000, rises = 0;
    logic [7:0] held_echo = 8'h00;
    bit         seen_frame = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cs_p = 1'b1; sck_p = 1'b0; run = 0; since_rise = 1000;
        end else begin
            run++;
            since_rise++;
            if (cs_p && !amp_cs_n) begin
                cs_falls++;
                if (seen_frame) check(run >= G, "R8 gap", run, G);
                check(exp_cmd_q.size() > 0, "R8 unexpected frame", 0, 1);
                if (exp_cmd_q.size() > 0)
                    check(amp_mosi == exp_cmd_q[0][7], "R3 first bit", amp_mosi, exp_cmd_q[0][7]);
                check(echo == held_echo, "R7 echo hold", echo, held_echo);
                rises = 0; run = 0;
            end
            if (!sck_p && amp_sck) begin
                check(run == P, "R4 low phase", run, P);
                if (exp_cmd_q.size() > 0 && rises < 8)
                    check(amp_mosi == exp_cmd_q[0][7-rises], "R1 bit order", amp_mosi, exp_cmd_q[0][7-rises]);
                rises++; run = 0;
            end
            if (sck_p && !amp_sck) begin
                check(run == P, "R4 high phase", run, P);
                run = 0;
            end
            if (!cs_p && amp_cs_n) begin
                check(run == T, "R5 trail", run, T);
                check(rises == 8, "R1 rise count", rises, 8);
                run = 0; since_rise = 0; seen_frame = 1'b1;
            end
            if (amp_cs_n && amp_sck) check(1'b0, "R5 sck idle", 1, 0);
            if (done) begin
                check(since_rise == 1, "R6 done delay", since_rise, 1);
                if (exp_cmd_q.size() > 0) begin
                    logic [7:0] ec, ee;
                    ec = exp_cmd_q.pop_front();
                    ee = exp_echo_q.pop_front();
                    check(amp_last == ec, "R2 received word", amp_last, ec);
                    check(echo == ee, "R7 echo", echo, ee);
                end
                held_echo = echo;
                frames_done++;
            end
            cs_p = amp_cs_n; sck_p = amp_sck;
        end
    end

    // Driver
    task automatic send(input logic [3:0] b, input logic [3:0] a,
                        input bit scramble, input bit poke_busy, input bit poke_gap);
        int target;
        target = frames_done + 1;
        @(negedge clk);
        gain_b = b; gain_a = a; start = 1'b1;
        exp_cmd_q.push_back({b, a});
        exp_echo_q.push_back(prev_cmd);
        prev_cmd = {b, a};
        frames_sent++;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            repeat (20) @(negedge clk);
            gain_b = ~b; gain_a = ~a;   // R2: must not reach the amplifier
        end
        if (poke_busy) begin
            repeat (10) @(negedge clk);
            start = 1'b1;               // R8: ignored mid-frame
            @(negedge clk);
            start = 1'b0;
        end
        while (frames_done < target) @(negedge clk);
        if (poke_gap) begin
            start = 1'b1;               // R8: ignored in the gap
            @(negedge clk);
            start = 1'b0;
        end
        repeat (G + 2) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; gain_a = 4'h0; gain_b = 4'h0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(amp_cs_n == 1'b1, "R9 cs reset", amp_cs_n, 1);
        check(amp_sck == 1'b0, "R9 sck reset", amp_sck, 0);
        check(amp_mosi == 1'b0, "R9 mosi reset", amp_mosi, 0);
        check(done == 1'b0, "R9 done reset", done, 0);
        check(echo == 8'h00, "R9 echo reset", echo, 0);
        check(amp_shdn == 1'b1, "R9 shdn in reset", amp_shdn, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(amp_shdn == 1'b0, "R9 shdn after reset", amp_shdn, 0);

        send(4'h0, 4'h1, 1'b0, 1'b0, 1'b0);
        send(4'h7, 4'h3, 1'b0, 1'b1, 1'b0);
        send(4'hA, 4'h5, 1'b1, 1'b0, 1'b0);
        send(4'h0, 4'hF, 1'b0, 1'b0, 1'b1);
        send(4'hF, 4'h0, 1'b1, 1'b1, 1'b1);
        send(4'h1, 4'h1, 1'b0, 1'b0, 1'b0);

        repeat (40) @(negedge clk);
        check(cs_falls == frames_sent, "R8 frame count", cs_falls, frames_sent);
        check(frames_done == frames_sent, "R6 done count", frames_done, frames_sent);
        check(amp_shdn == 1'b0, "R9 shdn idle", amp_shdn, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", frames_done, frames_sent);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule